// File: doc/BRIEF.md
# Timer Host Register Port

This block is the processor-facing side of a three-channel timer. A host reaches it through an 8-bit data bus with a 2-bit address and separate read and write strobes. Address 3 takes a control word. Addresses 0 to 2 reach the count of one channel each. For every channel the block decodes and keeps the counting mode, the BCD flag and the byte-access format. Byte-wide host writes become 16-bit count loads, and byte-wide host reads return bytes from the running count or from a frozen snapshot of it.

The counting logic sits outside this block. It receives each channel's mode, BCD flag, count value and a one-cycle load strobe. It returns its running count on `live_cnt`, and the block reads from that input or latches it. Read data is combinational while the read strobe is high. The read also moves the byte pointer at the clock edge that ends the read cycle.

Top module: `timer_host_port`

## Requirements
- R1: After reset, every channel reports mode 0, BCD 0, count 0 and no load strobe. Until a control word programs a channel, data writes to that channel cause no load, reads of it return 8'h00, and counter-latch commands aimed at it have no effect.
- R2: A write to address 3 with bits 5:4 not equal to 00 programs the channel named by bits 7:6 (00, 01 and 10 select channels 0, 1 and 2). That channel's mode output then equals bits 3:1 and its BCD output equals bit 0. A control word with bits 7:6 = 11 changes no channel.
- R3: With format 10 (low byte only), each data write loads {8'h00, data}. The load strobe is high for exactly one cycle, in the cycle after the write.
- R4: With format 01 (high byte only), each data write loads {data, 8'h00} with the same strobe timing as R3.
- R5: With format 11 (two bytes), the first data write is taken as the low byte and raises no strobe. The second write is the high byte and loads {second, first}, one cycle later.
- R6: Without a pending snapshot, reads return bytes of `live_cnt`. Format 10 always returns bits 7:0, format 01 always returns bits 15:8, and format 11 alternates between the low byte and then the high byte.
- R7: A control word with bits 5:4 = 00 freezes the named channel's current `live_cnt` as a snapshot. Reads then return the snapshot bytes, in the channel's format, however `live_cnt` moves. The channel's mode and format are unchanged.
- R8: A snapshot is held until it has been read completely: one byte in formats 10 and 01, two bytes in format 11. Latch commands issued while it is held are ignored. After the last snapshot byte, reads return `live_cnt` again.
- R9: Programming a channel restarts both its write and its read byte order at the low byte, and it discards any pending snapshot.
- R10: At most one channel's load strobe is high in any cycle, and reads of address 3 return 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address: 0 to 2 for channels, 3 for the control word |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| live_cnt | input | 48 | Running counts from the counting logic, channel i at bits 16i+15:16i |
| ch_mode | output | 9 | Counting mode per channel, channel i at bits 3i+2:3i |
| ch_bcd | output | 3 | BCD flag per channel |
| ch_load | output | 3 | One-cycle count-load strobe per channel |
| ch_count | output | 48 | Count value to load, channel i at bits 16i+15:16i |

## Verification
Each write format is driven with byte values whose halves differ, such as 5A, C3 and 34 followed by 12. A swapped, missing or unzeroed byte therefore shows in the loaded count, and the two-byte case confirms that the first byte raises no strobe. Reads use live counts whose two bytes differ (BEEF, 1357, ABCD), which separates low from high and shows the alternation in the two-byte format. Snapshots are read after `live_cnt` has moved to a different value, and a second latch command is issued mid-read, which separates snapshot data from live data and held latches from reloaded ones. Control words are rewritten in the middle of a byte pair and with a snapshot pending, which shows that byte order and snapshots are reset on programming.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;

    // Byte-access format field of the control word; 00 doubles as the
    // latch command code and as the "never programmed" channel state.
    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_HI   = 2'b01,
        ACC_LO   = 2'b10,
        ACC_PAIR = 2'b11
    } acc_fmt_e;

    typedef struct packed {
        logic [1:0] sel;
        acc_fmt_e   fmt;
        logic [2:0] mode;
        logic       bcd;
    } ctl_word_t;

endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
    import tmr_host_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 2
) (
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [NCH-1:0] prog,
    output logic [NCH-1:0] latch_cmd,
    output acc_fmt_e      new_fmt,
    output logic [2:0]    new_mode,
    output logic          new_bcd
);
    localparam logic [AW-1:0] CTL_ADDR = AW'(NCH);

    ctl_word_t cw;
    logic      ctl_wr;

    assign cw       = ctl_word_t'(wdata);
    assign ctl_wr   = wr_en && (addr == CTL_ADDR);
    assign new_fmt  = cw.fmt;
    assign new_mode = cw.mode;
    assign new_bcd  = cw.bcd;

    for (genvar i = 0; i < NCH; i++) begin : g_sel
        logic hit;
        assign hit          = ctl_wr && (cw.sel == 2'(i));
        assign prog[i]      = hit && (cw.fmt != ACC_NONE);
        assign latch_cmd[i] = hit && (cw.fmt == ACC_NONE);
    end

endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
    import tmr_host_pkg::*;
#(
    parameter int BW = 8,
    localparam int CW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog,
    input  logic          latch_cmd,
    input  acc_fmt_e      new_fmt,
    input  logic [2:0]    new_mode,
    input  logic          new_bcd,
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic [BW-1:0] wdata,
    input  logic [CW-1:0] live,
    output logic [BW-1:0] rbyte,
    output logic [2:0]    mode,
    output logic          bcd,
    output logic          load,
    output logic [CW-1:0] count
);
    typedef struct packed {
        acc_fmt_e      fmt;
        logic [2:0]    mode;
        logic          bcd;
        logic          wr_hi;
        logic          rd_hi;
        logic [BW-1:0] lsb_hold;
        logic          lat_vld;
        logic [CW-1:0] lat;
        logic          load;
        logic [CW-1:0] count;
    } chan_st_t;

    chan_st_t      st_d, st_q;
    logic [CW-1:0] src;
    logic          hi_sel;

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;

        src    = st_q.lat_vld ? st_q.lat : live;
        hi_sel = (st_q.fmt == ACC_HI) || ((st_q.fmt == ACC_PAIR) && st_q.rd_hi);
        if (st_q.fmt == ACC_NONE)
            rbyte = '0;
        else if (hi_sel)
            rbyte = src[CW-1:BW];
        else
            rbyte = src[BW-1:0];

        if (prog) begin
            st_d.fmt     = new_fmt;
            st_d.mode    = new_mode;
            st_d.bcd     = new_bcd;
            st_d.wr_hi   = 1'b0;
            st_d.rd_hi   = 1'b0;
            st_d.lat_vld = 1'b0;
        end else if (latch_cmd && (st_q.fmt != ACC_NONE) && !st_q.lat_vld) begin
            st_d.lat     = live;
            st_d.lat_vld = 1'b1;
            st_d.rd_hi   = 1'b0;
        end

        if (data_wr) begin
            unique case (st_q.fmt)
                ACC_LO: begin
                    st_d.count = {{BW{1'b0}}, wdata};
                    st_d.load  = 1'b1;
                end
                ACC_HI: begin
                    st_d.count = {wdata, {BW{1'b0}}};
                    st_d.load  = 1'b1;
                end
                ACC_PAIR: begin
                    if (!st_q.wr_hi) begin
                        st_d.lsb_hold = wdata;
                        st_d.wr_hi    = 1'b1;
                    end else begin
                        st_d.count = {wdata, st_q.lsb_hold};
                        st_d.load  = 1'b1;
                        st_d.wr_hi = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        if (data_rd && (st_q.fmt != ACC_NONE)) begin
            if (st_q.fmt == ACC_PAIR) begin
                st_d.rd_hi = !st_q.rd_hi;
                if (st_q.rd_hi) st_d.lat_vld = 1'b0;
            end else begin
                st_d.lat_vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode  = st_q.mode;
    assign bcd   = st_q.bcd;
    assign load  = st_q.load;
    assign count = st_q.count;

    // R1: an unprogrammed channel never loads
    assert_no_load_unprog_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fmt == ACC_NONE) |-> !st_q.load);

    // R4: high-byte-only loads carry a zero low byte
    assert_hi_only_zero_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.load && st_q.fmt == ACC_HI) |-> (st_q.count[BW-1:0] == '0));

    // R5: in two-byte format a load follows only the high-byte write
    assert_pair_load_after_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.load && st_q.fmt == ACC_PAIR) |-> $past(st_q.wr_hi));

    // R8: a held snapshot does not move
    assert_snapshot_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lat_vld && $past(st_q.lat_vld)) |-> $stable(st_q.lat));

    // R9: programming restarts byte order and drops the snapshot
    assert_prog_resets_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prog |=> (!st_q.wr_hi && !st_q.rd_hi && !st_q.lat_vld));

endmodule

// File: rtl/timer_host_port.sv
module timer_host_port
    import tmr_host_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 2,
    parameter int BW  = 8,
    localparam int CW = 2 * BW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BW-1:0]     wdata,
    output logic [BW-1:0]     rdata,
    input  logic [NCH*CW-1:0] live_cnt,
    output logic [NCH*3-1:0]  ch_mode,
    output logic [NCH-1:0]    ch_bcd,
    output logic [NCH-1:0]    ch_load,
    output logic [NCH*CW-1:0] ch_count
);
    logic [NCH-1:0]  prog, latch_cmd;
    acc_fmt_e        new_fmt;
    logic [2:0]      new_mode;
    logic            new_bcd;
    logic [BW-1:0]   rbyte [NCH];

    tmr_ctl_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .prog      (prog),
        .latch_cmd (latch_cmd),
        .new_fmt   (new_fmt),
        .new_mode  (new_mode),
        .new_bcd   (new_bcd)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = (addr == AW'(i));
        tmr_chan_port #(.BW(BW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .prog      (prog[i]),
            .latch_cmd (latch_cmd[i]),
            .new_fmt   (new_fmt),
            .new_mode  (new_mode),
            .new_bcd   (new_bcd),
            .data_wr   (wr_en && hit),
            .data_rd   (rd_en && hit),
            .wdata     (wdata),
            .live      (live_cnt[i*CW +: CW]),
            .rbyte     (rbyte[i]),
            .mode      (ch_mode[i*3 +: 3]),
            .bcd       (ch_bcd[i]),
            .load      (ch_load[i]),
            .count     (ch_count[i*CW +: CW])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++)
            if (rd_en && addr == AW'(i)) rdata = rbyte[i];
    end

    // R10: only one channel can be loaded per cycle
    assert_single_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_load));

    // R10: the control address reads as zero
    assert_ctl_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(NCH)) |-> (rdata == '0));

endmodule

// File: tb/tb_timer_host_port.sv
`timescale 1ns/1ps
module tb_timer_host_port;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  addr = 0;
    logic        wr_en = 0, rd_en = 0;
    logic [7:0]  wdata = 0;
    logic [7:0]  rdata;
    logic [15:0] live0 = 0, live1 = 0, live2 = 0;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd, ch_load;
    logic [47:0] ch_count;
    int checks = 0, errs = 0;
    bit done = 0;

    always #4 clk = ~clk;

    timer_host_port dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .live_cnt({live2, live1, live0}),
        .ch_mode(ch_mode), .ch_bcd(ch_bcd), .ch_load(ch_load), .ch_count(ch_count)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd_en = 1;
        #1 v = rdata;
        @(negedge clk); rd_en = 0;
    endtask

    function automatic logic [15:0] cnt(int i);
        return ch_count[i*16 +: 16];
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 mode", ch_mode, 0);
        chk("R1 bcd", ch_bcd, 0);
        chk("R1 load", ch_load, 0);
        chk("R1 count", ch_count[31:0], 0);
        live0 = 16'h1234;
        wr(2'd0, 8'h77);
        chk("R1 unprogrammed write", ch_load, 0);
        wr(2'd3, 8'b00_00_0000);
        rd(2'd0, v);
        chk("R1 unprogrammed read", v, 0);
    endtask

    task automatic t_decode();
        wr(2'd3, 8'b01_10_101_1);
        chk("R2 mode1", ch_mode[5:3], 5);
        chk("R2 bcd1", ch_bcd[1], 1);
        chk("R2 other modes", {ch_mode[8:6], ch_mode[2:0]}, 0);
        wr(2'd3, 8'b11_10_011_0);
        chk("R2 select 11 ignored", ch_mode, 9'b000_101_000);
        chk("R2 select 11 bcd", ch_bcd, 3'b010);
    endtask

    task automatic t_lsb_only();
        wr(2'd1, 8'h5A);
        chk("R3 load strobe", ch_load, 3'b010);
        chk("R3 count", cnt(1), 16'h005A);
        @(negedge clk);
        chk("R3 strobe one cycle", ch_load, 0);
    endtask

    task automatic t_msb_only();
        wr(2'd3, 8'b10_01_010_0);
        chk("R2 mode2", ch_mode[8:6], 2);
        wr(2'd2, 8'hC3);
        chk("R4 load strobe", ch_load, 3'b100);
        chk("R4 count", cnt(2), 16'hC300);
    endtask

    task automatic t_pair();
        wr(2'd3, 8'b00_11_011_0);
        wr(2'd0, 8'h34);
        chk("R5 no strobe after lsb", ch_load, 0);
        wr(2'd0, 8'h12);
        chk("R5 strobe after msb", ch_load, 3'b001);
        chk("R5 count", cnt(0), 16'h1234);
    endtask

    task automatic t_reads();
        logic [7:0] v;
        live0 = 16'hBEEF; live1 = 16'h1357; live2 = 16'hABCD;
        rd(2'd0, v); chk("R6 pair low", v, 8'hEF);
        rd(2'd0, v); chk("R6 pair high", v, 8'hBE);
        rd(2'd1, v); chk("R6 lsb-only", v, 8'h57);
        rd(2'd1, v); chk("R6 lsb-only again", v, 8'h57);
        rd(2'd2, v); chk("R6 msb-only", v, 8'hAB);
        rd(2'd3, v); chk("R10 ctl read zero", v, 0);
    endtask

    task automatic t_latch();
        logic [7:0] v;
        live0 = 16'h4321;
        wr(2'd3, 8'b00_00_0000);
        live0 = 16'h9999;
        chk("R7 mode kept", ch_mode[2:0], 3);
        rd(2'd0, v); chk("R7 snapshot low", v, 8'h21);
        wr(2'd3, 8'b00_00_0000);
        rd(2'd0, v); chk("R8 second latch ignored", v, 8'h43);
        rd(2'd0, v); chk("R8 live after read", v, 8'h99);
        rd(2'd0, v); chk("R8 live high", v, 8'h99);
        live1 = 16'h00F0;
        wr(2'd3, 8'b01_00_0000);
        live1 = 16'h0001;
        rd(2'd1, v); chk("R7 lsb-only snapshot", v, 8'hF0);
        rd(2'd1, v); chk("R8 lsb-only released", v, 8'h01);
    endtask

    task automatic t_reprogram();
        logic [7:0] v;
        wr(2'd0, 8'h11);
        wr(2'd3, 8'b00_11_000_0);
        chk("R9 mode rewritten", ch_mode[2:0], 0);
        wr(2'd0, 8'h22);
        chk("R9 no strobe after first byte", ch_load, 0);
        wr(2'd0, 8'h33);
        chk("R9 write order restarted", cnt(0), 16'h3322);
        live0 = 16'h5555;
        wr(2'd3, 8'b00_00_0000);
        live0 = 16'h6677;
        wr(2'd3, 8'b00_11_000_0);
        rd(2'd0, v); chk("R9 snapshot dropped", v, 8'h77);
        wr(2'd3, 8'b00_11_000_0);
        rd(2'd0, v); chk("R9 read order restarted", v, 8'h77);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_lsb_only();
        t_msb_only();
        t_pair();
        t_reads();
        t_latch();
        t_reprogram();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule